// File: doc/BRIEF.md
# Five-Letter Word Display Sequencer

This block drives a single seven-segment digit so that it spells a fixed five-letter greeting, one letter at a time. A small state register holds the position in the word. On each clock edge where the advance enable is high, it moves to the next letter. After the last letter it returns to the first. The enable is normally a slow tick from a divider elsewhere, so the letters change at a rate a person can read.

The position is kept as a 3-bit binary code and is also brought out for observation. The segment pattern is decoded from that code with combinational logic. The word contains a doubled letter, so two neighbouring positions decode to the same glyph and the digit does not change between them. Codes the sequence never uses show a blank digit and lead back to the first letter on the next enabled step.

Top module: `word_disp_seq`

## Requirements
- R1: When `rst_i` is high at a rising clock edge, `state_o` becomes 3'b000 and `seg_o` shows the H glyph after that edge.
- R2: At a rising edge where `rst_i` and `step_en_i` are both low, `state_o` and `seg_o` keep their values.
- R3: At a rising edge with `step_en_i` high and `rst_i` low, a state below 3'b100 advances by one (000→001→010→011→100).
- R4: At a rising edge with `step_en_i` high and `rst_i` low, state 3'b100 wraps to 3'b000.
- R5: `seg_o` is active high in bit order {g,f,e,d,c,b,a}. State 000 shows H = 7'b1110110, state 001 shows E = 7'b1111001, and state 100 shows O = 7'b0111111.
- R6: States 010 and 011 both show L = 7'b0111000, so stepping from 010 to 011 leaves `seg_o` unchanged.
- R7: When `rst_i` and `step_en_i` are both high at the same edge, reset wins and the state becomes 3'b000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| step_en_i | input | 1 | Advance enable; one letter per edge while high |
| seg_o | output | 7 | Segment drive {g,f,e,d,c,b,a}, active high |
| state_o | output | 3 | Current letter position, binary coded |

## Verification
Two functions can meet at the same edge: the synchronous reset and the advance step. The bench raises both `rst_i` and `step_en_i` in one cycle. It does this at several positions, including the last letter, where a step alone would wrap to the first letter and so look the same as a reset. It also does this at a middle letter, where a step alone would move forward. In every case the scoreboard expects state 000 with the H glyph, so a design that let the step win would be caught at the middle position.

// File: rtl/word_disp_pkg.sv
package word_disp_pkg;

    localparam int ST_W  = 3;
    localparam int SEG_W = 7;

    // Segment order {g,f,e,d,c,b,a}, active high
    localparam logic [SEG_W-1:0] GLYPH_H     = 7'b1110110;
    localparam logic [SEG_W-1:0] GLYPH_E     = 7'b1111001;
    localparam logic [SEG_W-1:0] GLYPH_L     = 7'b0111000;
    localparam logic [SEG_W-1:0] GLYPH_O     = 7'b0111111;
    localparam logic [SEG_W-1:0] GLYPH_BLANK = 7'b0000000;

    typedef struct packed {
        logic [ST_W-1:0] pos;
    } seq_regs_t;

endpackage

// File: rtl/wd_step.sv
module wd_step #(
    parameter int ST_W    = 3,
    parameter int LAST_ST = 4
) (
    input  logic [ST_W-1:0] cur_i,
    input  logic            rst_i,
    input  logic            step_en_i,
    output logic [ST_W-1:0] nxt_o
);

    localparam logic [ST_W-1:0] FIRST = '0;
    localparam logic [ST_W-1:0] LAST  = ST_W'(LAST_ST);

    always_comb begin
        nxt_o = cur_i;
        if (rst_i) begin
            nxt_o = FIRST;
        end else if (step_en_i) begin
            if (cur_i < LAST) begin
                nxt_o = cur_i + ST_W'(1);
            end else begin
                // last letter wraps; unused codes recover to the first letter
                nxt_o = FIRST;
            end
        end
    end

endmodule

// File: rtl/wd_glyph.sv
module wd_glyph
    import word_disp_pkg::*;
#(
    parameter int ST_W = 3
) (
    input  logic [ST_W-1:0]  pos_i,
    output logic [SEG_W-1:0] seg_o
);

    always_comb begin
        case (pos_i)
            ST_W'(0): seg_o = GLYPH_H;
            ST_W'(1): seg_o = GLYPH_E;
            ST_W'(2): seg_o = GLYPH_L;
            ST_W'(3): seg_o = GLYPH_L;
            ST_W'(4): seg_o = GLYPH_O;
            default:  seg_o = GLYPH_BLANK;
        endcase
    end

endmodule

// File: rtl/word_disp_seq.sv
module word_disp_seq
    import word_disp_pkg::*;
#(
    parameter int LAST_ST = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             step_en_i,
    output logic [SEG_W-1:0] seg_o,
    output logic [ST_W-1:0]  state_o
);

    seq_regs_t regs_d, regs_q;
    logic [ST_W-1:0] pos_nxt;

    wd_step #(
        .ST_W   (ST_W),
        .LAST_ST(LAST_ST)
    ) i_step (
        .cur_i    (regs_q.pos),
        .rst_i    (rst_i),
        .step_en_i(step_en_i),
        .nxt_o    (pos_nxt)
    );

    always_comb begin
        regs_d     = regs_q;
        regs_d.pos = pos_nxt;
    end

    always_ff @(posedge clk_i) begin
        regs_q <= regs_d;
    end

    wd_glyph #(
        .ST_W(ST_W)
    ) i_glyph (
        .pos_i(regs_q.pos),
        .seg_o(seg_o)
    );

    assign state_o = regs_q.pos;

    // R1 R7
    reset_to_first_chk: assert property (@(posedge clk_i)
        rst_i |=> (state_o == '0 && seg_o == GLYPH_H));

    // R2
    hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !step_en_i |=> ($stable(state_o) && $stable(seg_o)));

    // R3
    advance_one_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_en_i && state_o < ST_W'(LAST_ST)) |=> state_o == $past(state_o) + ST_W'(1));

    // R4
    wrap_to_first_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_en_i && state_o == ST_W'(LAST_ST)) |=> state_o == '0);

    // R5
    glyph_lit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o <= ST_W'(LAST_ST)) |-> seg_o != GLYPH_BLANK);

    // R6
    double_letter_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == ST_W'(3) && $past(state_o) == ST_W'(2)) |-> $stable(seg_o));

endmodule

// File: tb/test_word_disp_seq.sv
module test_word_disp_seq;

    localparam time CLK_P = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_en = 1'b0;
    logic [6:0] seg;
    logic [2:0] state;

    int n_vec  = 0;
    int n_bad  = 0;
    int m_state = 0;
    bit done   = 1'b0;

    logic [9:0] exp_q[$];
    string      tag_q[$];

    word_disp_seq i_word_disp_seq (
        .clk_i    (clk),
        .rst_i    (rst),
        .step_en_i(step_en),
        .seg_o    (seg),
        .state_o  (state)
    );

    always #(CLK_P/2) clk = ~clk;

    // R5 R6: glyph table {g,f,e,d,c,b,a}
    function automatic logic [6:0] glyph(input int s);
        case (s)
            0: return 7'b1110110;
            1: return 7'b1111001;
            2: return 7'b0111000;
            3: return 7'b0111000;
            4: return 7'b0111111;
            default: return 7'b0000000;
        endcase
    endfunction

    task automatic apply(input bit en, input bit r);
        string tag;
        @(negedge clk);
        step_en = en;
        rst     = r;
        if (r) begin
            tag = "R1/R7";
            m_state = 0;
        end else if (!en) begin
            tag = "R2";
        end else if (m_state == 4) begin
            tag = "R4";
            m_state = 0;
        end else begin
            tag = "R3";
            m_state = m_state + 1;
        end
        exp_q.push_back({3'(m_state), glyph(m_state)});
        tag_q.push_back(tag);
    endtask

    // monitor
    always begin
        logic [9:0] e;
        string t;
        @(posedge clk);
        #(CLK_P/4);
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if ({state, seg} !== e) begin
                n_bad++;
                $display("FAIL %s (glyph R5/R6): state=%b seg=%b expected state=%b seg=%b",
                         t, state, seg, e[9:7], e[6:0]);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        apply(1'b0, 1'b1);
        apply(1'b0, 1'b1);
        // R3 R4 R5 R6: two full passes through the word
        for (int i = 0; i < 11; i++) apply(1'b1, 1'b0);
        // R2 hold with idle enable, then sparse stepping
        apply(1'b0, 1'b0);
        apply(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) apply(i[0], 1'b0);
        // R7 reset and step together at a middle letter
        apply(1'b1, 1'b0);
        apply(1'b1, 1'b1);
        apply(1'b1, 1'b0);
        apply(1'b1, 1'b0);
        apply(1'b1, 1'b0);
        apply(1'b1, 1'b0);
        // R7 reset and step together on the last letter
        apply(1'b1, 1'b1);
        // R6 dwell on the doubled letter
        apply(1'b1, 1'b0);
        apply(1'b1, 1'b0);
        apply(1'b0, 1'b0);
        apply(1'b1, 1'b0);
        apply(1'b0, 1'b0);
        // R1 reset with idle enable mid-word
        apply(1'b0, 1'b1);
        apply(1'b0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule